// File: doc/BRIEF.md
# Clipped Affine Pixel Remapper

This block sits in a video path that carries 24-bit RGB pixels, one per pixel clock, with horizontal and vertical sync and a data-enable. It boosts pixel transmittance so that a frame still looks right when the backlight has been dimmed. For every frame it applies one transfer function, set by two bounds. A value at or under the low bound goes to zero. A value at or over the high bound goes to full scale. Values between the bounds are stretched linearly across the whole 0..255 range. All three colour channels use the same mapping.

An outside source supplies the bounds with a load strobe, and they can arrive at any time. The block keeps them in a holding register. It moves them into the working set only when the vertical sync rises, so no frame is ever processed with a mix of old and new bounds. The division in the stretch is replaced by a reciprocal. The reciprocal is read from a computed table when the bounds are applied, so the pixel path has only a subtract, a multiply and a saturate. Pixel data and all timing signals leave the block exactly three clocks after they enter it.

Top module: `pix_remap_top`

## Requirements
- R1: During and after synchronous reset, the outputs are all zero and the working bounds are low 0 and high 255, which maps every value to itself.
- R2: An output pixel appears exactly 3 clocks after its input pixel.
- R3: The hsync, vsync and data-enable outputs are copies of their inputs delayed by exactly 3 clocks.
- R4: When data-enable is low, the output pixel is zero whatever the input pixel or hsync is.
- R5: With high > low, a channel value x <= low maps to 0.
- R6: With high > low, a channel value x >= high maps to 255.
- R7: With low < x < high, a channel value maps to floor(255*(x-low)/(high-low)).
- R8: When high <= low, every channel value passes through unchanged.
- R9: Bounds loaded while a frame is in progress do not affect pixels until the vertical sync input next rises. The bounds held at that edge apply from the following pixel.
- R10: When several loads occur between two vsync rises, the last one wins. A load in the same clock as a vsync rise is held over to the next rise.
- R11: The channels pack as red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Each channel is mapped on its own with the shared bounds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| vid_hs_i | input | 1 | Horizontal sync in |
| vid_vs_i | input | 1 | Vertical sync in; its rising edge applies held bounds |
| vid_de_i | input | 1 | Data-enable in; pixel valid when high |
| vid_pix_i | input | 24 | RGB pixel in (R 23:16, G 15:8, B 7:0) |
| bnd_ld | input | 1 | Strobe that captures the bounds into the holding register |
| bnd_lo | input | 8 | Low clipping bound |
| bnd_hi | input | 8 | High clipping bound |
| vid_hs_o | output | 1 | Horizontal sync out, 3 clocks late |
| vid_vs_o | output | 1 | Vertical sync out, 3 clocks late |
| vid_de_o | output | 1 | Data-enable out, 3 clocks late |
| vid_pix_o | output | 24 | Remapped RGB pixel out |

## Verification
The clip assertions assume that the working bounds do not change while a pixel is in the three-stage pipe. The bounds move only on a vsync rise. The stimulus raises vsync only after several blank clocks and keeps data-enable low around it. Bounds loads are allowed mid-line and on the vsync edge itself, because the bench models the holding register cycle by cycle. The sweeps walk every 8-bit value through each channel for several bound pairs, including adjacent, equal and inverted pairs.

// File: rtl/pix_remap_pkg.sv
package pix_remap_pkg;

    parameter int PIX_W      = 8;
    parameter int CH_N       = 3;
    parameter int FRAC_W     = 16;
    parameter int PIPE_DEPTH = 3;

    localparam int RECIP_W = PIX_W + FRAC_W;
    localparam int PROD_W  = PIX_W + RECIP_W;
    localparam int PIX_MAX = (1 << PIX_W) - 1;
    localparam int BUS_W   = PIX_W * CH_N;
    localparam int LUT_N   = 1 << PIX_W;

    typedef logic [PIX_W-1:0]   pix_t;
    typedef logic [RECIP_W-1:0] recip_t;
    typedef logic [PROD_W-1:0]  prod_t;

    // working transfer parameters for one frame
    typedef struct packed {
        pix_t   lo;
        pix_t   hi;
        recip_t recip;
        logic   ident;
    } xfer_t;

    typedef struct packed {
        logic hs;
        logic vs;
        logic de;
    } vtime_t;

    typedef struct packed {
        logic   de;
        logic   ident;
        logic   below;
        logic   above;
        pix_t   x;
        pix_t   n;
        recip_t recip;
    } lane_s1_t;

    typedef struct packed {
        logic  de;
        logic  ident;
        logic  below;
        logic  above;
        pix_t  x;
        prod_t prod;
    } lane_s2_t;

    // ceil(PIX_MAX * 2^FRAC_W / d): exact floor division for n <= d < 2^(FRAC_W/2)
    function automatic recip_t recip_of(input int unsigned d);
        int unsigned num;
        if (d == 0) return '0;
        num = (int'(PIX_MAX) << FRAC_W) + d - 1;
        return recip_t'(num / d);
    endfunction

    function automatic pix_t prod_sat(input prod_t p);
        if (|p[PROD_W-1:FRAC_W+PIX_W]) return pix_t'(PIX_MAX);
        return p[FRAC_W +: PIX_W];
    endfunction

endpackage

// File: rtl/pix_recip_lut.sv
module pix_recip_lut
    import pix_remap_pkg::*;
(
    input  pix_t   span,
    output recip_t recip
);
    recip_t tbl [LUT_N];

    for (genvar gi = 0; gi < LUT_N; gi++) begin : g_tbl
        assign tbl[gi] = recip_of(gi);
    end

    assign recip = tbl[span];
endmodule

// File: rtl/pix_bound_regs.sv
module pix_bound_regs
    import pix_remap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld,
    input  pix_t  ld_lo,
    input  pix_t  ld_hi,
    input  logic  vs_in,
    output xfer_t act
);
    pix_t   sh_lo, sh_hi;
    recip_t sh_recip;
    logic   vs_prev;
    logic   vs_rise;
    pix_t   sh_span;

    assign vs_rise = vs_in & ~vs_prev;
    assign sh_span = sh_hi - sh_lo;

    pix_recip_lut i_lut (
        .span  (sh_span),
        .recip (sh_recip)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_lo     <= '0;
            sh_hi     <= pix_t'(PIX_MAX);
            vs_prev   <= 1'b0;
            act.lo    <= '0;
            act.hi    <= pix_t'(PIX_MAX);
            act.recip <= recip_of(PIX_MAX);
            act.ident <= 1'b0;
        end else begin
            vs_prev <= vs_in;
            if (ld) begin
                sh_lo <= ld_lo;
                sh_hi <= ld_hi;
            end
            if (vs_rise) begin
                act.lo    <= sh_lo;
                act.hi    <= sh_hi;
                act.recip <= sh_recip;
                act.ident <= (sh_hi <= sh_lo);
            end
        end
    end

    // R9
    params_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !vs_rise |=> (act == $past(act)));

    // R10
    late_load_chk: assert property (@(posedge clk) disable iff (rst)
        (vs_rise && ld && (ld_lo != sh_lo)) |=> (act.lo != sh_lo));
endmodule

// File: rtl/pix_remap_lane.sv
module pix_remap_lane
    import pix_remap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  de_in,
    input  pix_t  x_in,
    input  xfer_t xf,
    output pix_t  y_out
);
    lane_s1_t s1;
    lane_s2_t s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1    <= '0;
            s2    <= '0;
            y_out <= '0;
        end else begin
            s1.de    <= de_in;
            s1.ident <= xf.ident;
            s1.below <= (x_in <= xf.lo);
            s1.above <= (x_in >= xf.hi);
            s1.x     <= x_in;
            s1.n     <= x_in - xf.lo;
            s1.recip <= xf.recip;

            s2.de    <= s1.de;
            s2.ident <= s1.ident;
            s2.below <= s1.below;
            s2.above <= s1.above;
            s2.x     <= s1.x;
            s2.prod  <= prod_t'(s1.n) * prod_t'(s1.recip);

            if (!s2.de)        y_out <= '0;
            else if (s2.ident) y_out <= s2.x;
            else if (s2.below) y_out <= '0;
            else if (s2.above) y_out <= pix_t'(PIX_MAX);
            else               y_out <= prod_sat(s2.prod);
        end
    end

    // R5
    clip_low_chk: assert property (@(posedge clk) disable iff (rst)
        (de_in && !xf.ident && (x_in <= xf.lo)) |-> ##3 (y_out == '0));

    // R6
    clip_high_chk: assert property (@(posedge clk) disable iff (rst)
        (de_in && !xf.ident && (x_in > xf.lo) && (x_in >= xf.hi))
            |-> ##3 (y_out == pix_t'(PIX_MAX)));
endmodule

// File: rtl/pix_vtime_delay.sv
module pix_vtime_delay
    import pix_remap_pkg::*;
#(
    parameter int DEPTH = PIPE_DEPTH
) (
    input  logic   clk,
    input  logic   rst,
    input  vtime_t t_in,
    output vtime_t t_out
);
    vtime_t stg [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_stg
        if (gi == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) stg[gi] <= '0;
                else     stg[gi] <= t_in;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) stg[gi] <= '0;
                else     stg[gi] <= stg[gi-1];
            end
        end
    end

    assign t_out = stg[DEPTH-1];
endmodule

// File: rtl/pix_remap_top.sv
module pix_remap_top
    import pix_remap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        vid_hs_i,
    input  logic        vid_vs_i,
    input  logic        vid_de_i,
    input  logic [23:0] vid_pix_i,
    input  logic        bnd_ld,
    input  logic [7:0]  bnd_lo,
    input  logic [7:0]  bnd_hi,
    output logic        vid_hs_o,
    output logic        vid_vs_o,
    output logic        vid_de_o,
    output logic [23:0] vid_pix_o
);
    xfer_t  act;
    vtime_t t_in, t_out;
    logic [1:0] warm_q;

    pix_bound_regs i_bounds (
        .clk   (clk),
        .rst   (rst),
        .ld    (bnd_ld),
        .ld_lo (bnd_lo),
        .ld_hi (bnd_hi),
        .vs_in (vid_vs_i),
        .act   (act)
    );

    for (genvar gc = 0; gc < CH_N; gc++) begin : g_lane
        pix_remap_lane i_lane (
            .clk   (clk),
            .rst   (rst),
            .de_in (vid_de_i),
            .x_in  (vid_pix_i[gc*PIX_W +: PIX_W]),
            .xf    (act),
            .y_out (vid_pix_o[gc*PIX_W +: PIX_W])
        );
    end

    assign t_in = '{hs: vid_hs_i, vs: vid_vs_i, de: vid_de_i};

    pix_vtime_delay #(.DEPTH(PIPE_DEPTH)) i_delay (
        .clk   (clk),
        .rst   (rst),
        .t_in  (t_in),
        .t_out (t_out)
    );

    assign vid_hs_o = t_out.hs;
    assign vid_vs_o = t_out.vs;
    assign vid_de_o = t_out.de;

    always_ff @(posedge clk) begin
        if (rst)                 warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    // R4
    blank_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !vid_de_o |-> (vid_pix_o == '0));

    // R3
    sync_align_chk: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd3) |->
            ({vid_hs_o, vid_vs_o, vid_de_o} == $past({vid_hs_i, vid_vs_i, vid_de_i}, 3)));

    // R1
    reset_out_chk: assert property (@(posedge clk)
        $past(rst) |-> (vid_pix_o == '0 && !vid_de_o && !vid_hs_o && !vid_vs_o));
endmodule

// File: tb/test_pix_remap_top.sv
`timescale 1ns/1ps
module test_pix_remap_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hs_i = 1'b0, vs_i = 1'b0, de_i = 1'b0;
    logic [23:0] pix_i = '0;
    logic        ld = 1'b0;
    logic [7:0]  lo_i = '0, hi_i = '0;
    logic        hs_o, vs_o, de_o;
    logic [23:0] pix_o;

    int checks = 0;
    int errors = 0;

    // bench model of the bound registers
    int m_act_lo = 0, m_act_hi = 255;
    int m_sh_lo = 0, m_sh_hi = 255;
    bit m_vs_prev = 1'b0;

    logic [23:0] h_pix  [3];
    logic [2:0]  h_sync [3];
    string       h_tag  [3];

    always #2 clk = ~clk;

    pix_remap_top i_pix_remap_top (
        .clk       (clk),
        .rst       (rst),
        .vid_hs_i  (hs_i),
        .vid_vs_i  (vs_i),
        .vid_de_i  (de_i),
        .vid_pix_i (pix_i),
        .bnd_ld    (ld),
        .bnd_lo    (lo_i),
        .bnd_hi    (hi_i),
        .vid_hs_o  (hs_o),
        .vid_vs_o  (vs_o),
        .vid_de_o  (de_o),
        .vid_pix_o (pix_o)
    );

    function automatic logic [7:0] ref_map(input int x, input int lo, input int hi);
        if (hi <= lo) return 8'(x);
        if (x <= lo)  return 8'd0;
        if (x >= hi)  return 8'd255;
        return 8'((255 * (x - lo)) / (hi - lo));
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic tick(input bit de, input bit hs, input bit vs, input logic [23:0] pix,
                        input bit load, input int lo, input int hi, input string tag);
        logic [23:0] exp;
        @(negedge clk);
        checks++;
        if (pix_o !== h_pix[2]) begin
            errors++;
            $display("FAIL %s pixel: got %h expected %h", h_tag[2], pix_o, h_pix[2]);
        end
        checks++;
        if ({hs_o, vs_o, de_o} !== h_sync[2]) begin
            errors++;
            $display("FAIL R3 syncs {hs,vs,de}: got %b expected %b", {hs_o, vs_o, de_o}, h_sync[2]);
        end
        de_i = de; hs_i = hs; vs_i = vs; pix_i = pix;
        ld = load; lo_i = 8'(lo); hi_i = 8'(hi);
        if (de)
            exp = {ref_map(int'(pix[23:16]), m_act_lo, m_act_hi),
                   ref_map(int'(pix[15:8]),  m_act_lo, m_act_hi),
                   ref_map(int'(pix[7:0]),   m_act_lo, m_act_hi)};
        else
            exp = '0;
        for (int k = 2; k > 0; k--) begin
            h_pix[k] = h_pix[k-1]; h_sync[k] = h_sync[k-1]; h_tag[k] = h_tag[k-1];
        end
        h_pix[0]  = exp;
        h_sync[0] = {hs, vs, de};
        h_tag[0]  = de ? tag : "R4";
        if (vs && !m_vs_prev) begin
            m_act_lo = m_sh_lo;
            m_act_hi = m_sh_hi;
        end
        m_vs_prev = vs;
        if (load) begin
            m_sh_lo = lo;
            m_sh_hi = hi;
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 24'h0, 0, 0, 0, tag);
    endtask

    // blanking with hsync high and junk data: output must stay zero (R4)
    task automatic hblank();
        for (int i = 0; i < 4; i++) tick(0, 1, 0, 24'hA5C3FF, 0, 0, 0, "R4");
    endtask

    // every 8-bit value on red, mirrored on green, scrambled on blue (R11)
    task automatic line(input string tag);
        for (int x = 0; x < 256; x++)
            tick(1, 0, 0, {8'(x), 8'(255 - x), 8'((x * 7 + 3) & 255)}, 0, 0, 0, tag);
    endtask

    task automatic vpulse(input string tag);
        idle(2, tag);
        tick(0, 0, 1, 24'h0, 0, 0, 0, tag);
        tick(0, 0, 1, 24'h0, 0, 0, 0, tag);
        idle(3, tag);
    endtask

    task automatic set_bounds(input int lo, input int hi, input string tag);
        tick(0, 0, 0, 24'h0, 1, lo, hi, tag);
        vpulse(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (run hung)");
        summary();
        $finish;
    end

    initial begin
        for (int k = 0; k < 3; k++) begin
            h_pix[k] = '0; h_sync[k] = '0; h_tag[k] = "R1";
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: zero outputs after reset, identity bounds in force
        idle(4, "R1");
        hblank();
        line("R1");
        // R2: latency of three clocks with a plain stretch
        set_bounds(30, 200, "R2");
        hblank();
        line("R2");
        // R5 R6 R7: clip and stretch sweeps
        set_bounds(0, 255, "R7");   hblank(); line("R7");
        set_bounds(100, 101, "R5"); hblank(); line("R5");
        set_bounds(0, 1, "R6");     hblank(); line("R6");
        set_bounds(254, 255, "R6"); hblank(); line("R6");
        set_bounds(17, 143, "R7");  hblank(); line("R7");
        // R8: equal and inverted bounds pass values through
        set_bounds(50, 50, "R8");   hblank(); line("R8");
        set_bounds(200, 60, "R8");  hblank(); line("R8");

        // R9: a load in mid-line leaves the running frame alone
        set_bounds(40, 180, "R9");
        hblank();
        for (int x = 0; x < 128; x++)
            tick(1, 0, 0, {8'(x), 8'(x + 64), 8'(255 - x)}, 0, 0, 0, "R9");
        tick(1, 0, 0, 24'h7F7F7F, 1, 10, 20, "R9");
        for (int x = 128; x < 256; x++)
            tick(1, 0, 0, {8'(x), 8'(x - 64), 8'(255 - x)}, 0, 0, 0, "R9");
        hblank();
        vpulse("R9");
        line("R9");

        // R10: last load wins; a load on the vsync edge waits a frame
        tick(0, 0, 0, 24'h0, 1, 1, 2, "R10");
        tick(0, 0, 0, 24'h0, 1, 60, 90, "R10");
        idle(2, "R10");
        tick(0, 0, 1, 24'h0, 1, 5, 250, "R10");
        tick(0, 0, 0, 24'h0, 0, 0, 0, "R10");
        idle(3, "R10");
        line("R10");
        vpulse("R10");
        line("R10");

        idle(6, "R4");
        summary();
        $finish;
    end

endmodule